// File: doc/BRIEF.md
# Sequenced PIO Output Writer

This block turns data bytes that arrive over a serial write into the drive state of twelve general-purpose pins. The pins form a wide group of eight and a narrow group of four. The serial front end reports three things. It pulses `byte_rx` once the last bit of a byte has been shifted in. It pulses `sck_fall` on each later falling serial clock edge. It pulses `wr_start` when a WRITE to a pin group has been decoded. Chip select is passed through unchanged. A byte takes effect on the falling clock edge that follows its last bit. When no such edge comes, it takes effect on the rising edge of chip select.

In simultaneous mode (`hc_mode` low), all pins of the addressed group take the new byte in the same cycle. A write that starts at the wide group keeps alternating between the two groups for as long as bytes arrive. In sequenced mode (`hc_mode` high), the block updates the pins one at a time, in ascending order. Each pin is first released for a fixed settle time and then driven for a fixed ramp time before the next pin starts. Cycle counts stand in for the settle and ramp intervals. A pin's direction and driver type are sampled only at the moment the sequence reaches that pin.

Top module: `pio_seq_writer`

## Requirements
- R1: A received byte is applied on the first `sck_fall` pulse after its `byte_rx` pulse. If chip select rises first, the byte is applied on that rising edge instead. In both cases the new pin state is visible one clock after the triggering cycle.
- R2: Bytes of a write are applied only if `wr_enable` was high at that write's `wr_start` pulse. Otherwise every byte of the write leaves all outputs unchanged.
- R3: In simultaneous mode, a byte updates every pin of its group in the same cycle, and the other group is unchanged. The wide group is pins 0..7 from byte bits 7:0. The narrow group is pins 8..11 from byte bits 3:0.
- R4: In simultaneous mode, a write started at the wide group (`wr_grp_b`=0) sends bytes to the wide group, then the narrow group, then the wide group, and so on. A write started at the narrow group (`wr_grp_b`=1) applies its first byte only and ignores the rest.
- R5: In sequenced mode, an accepted byte updates its group one pin at a time, in ascending order, starting at pin 0 (wide group) or pin 8 (narrow group). Each pin's output enable is low for TRI_CYC cycles, starting the cycle after the trigger. The pin then shows its new state for RAMP_CYC cycles before the next pin starts. This applies to every pin of the group, including inputs and pins whose value does not change.
- R6: In sequenced mode, a write started at the wide group accepts one more byte for pins 8..11. That byte must be applied before pin 7 finishes. Pin 8 then starts GAP_CYC cycles after pin 7 ends. If no such byte is applied, the sequence ends after pin 7.
- R7: In sequenced mode, a change on `cfg_dir` or `cfg_od` has no effect on a pin until a later sequenced write reaches that pin.
- R8: `busy` is high from the cycle after a sequenced update is triggered until its last pin's ramp ends. Bytes applied while `busy` is high are ignored, except the narrow-group byte of R6.
- R9: Pin drive: `cfg_dir` bit 1 means output and 0 means input. `cfg_od` bit 1 means open-drain and 0 means push-pull. An input has `pio_oe`=0. A push-pull output has `pio_oe`=1 and `pio_out` equal to its value. An open-drain output has `pio_out`=0 and `pio_oe` equal to the inverse of its value. In simultaneous mode, pin drive follows `cfg_dir` and `cfg_od` directly.
- R10: During and after reset, every pin value is 0 and `busy` is 0. With an all-zero configuration, `pio_oe` and `pio_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, as seen by the serial front end |
| wr_start | input | 1 | Pulse: a WRITE to a pin group has been decoded |
| wr_grp_b | input | 1 | With wr_start: 0 = start at the wide group, 1 = start at the narrow group |
| wr_enable | input | 1 | Write-enable latch state, sampled at wr_start |
| byte_rx | input | 1 | Pulse: a full data byte has been shifted in |
| byte_data | input | GRP_A_W | The received byte, valid with byte_rx |
| sck_fall | input | 1 | Pulse per falling serial clock edge |
| hc_mode | input | 1 | 0 = simultaneous update, 1 = sequenced update |
| cfg_dir | input | NPIO | Per-pin direction, 1 = output |
| cfg_od | input | NPIO | Per-pin driver type, 1 = open-drain |
| pio_out | output | NPIO | Per-pin output value |
| pio_oe | output | NPIO | Per-pin output enable |
| busy | output | 1 | A sequenced update is running |

## Verification
The bench builds the block with TRI_CYC=5, RAMP_CYC=3 and GAP_CYC=4 in place of the microsecond-scale defaults. With these values, a full twelve-pin sequence, including the gap between the groups, lasts about one hundred cycles. The bench can therefore check every pin's release window, the gap and the fall of `busy` cycle by cycle. The short sequence also leaves room to place the second byte well inside the wide-group run and a stray third byte afterwards. Simultaneous-mode writes use random group starts, byte counts, configurations and end styles.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TRI  = 2'd1,
    SEQ_RAMP = 2'd2,
    SEQ_GAP  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pio_commit_trig.sv
// Holds a received byte until the edge that applies it.
module pio_commit_trig #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              byte_rx,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              sck_fall,
  output logic              commit,
  output logic [BYTE_W-1:0] commit_data,
  output logic              cs_rise
);
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] data_q, data_d;
  logic              cs_q;

  always_comb begin
    cs_rise     = cs_n & ~cs_q;
    commit      = pend_q & (sck_fall | cs_rise);
    commit_data = data_q;
    pend_d      = pend_q;
    data_d      = data_q;
    if (commit) pend_d = 1'b0;
    if (byte_rx && !cs_n) begin
      pend_d = 1'b1;
      data_d = byte_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      data_q <= '0;
      cs_q   <= 1'b1;
    end else begin
      pend_q <= pend_d;
      cs_q   <= cs_n;
      if (byte_rx) data_q <= data_d;
    end
  end
endmodule

// File: rtl/pio_delay_timer.sv
// Down counter: expired is high once the loaded interval has elapsed.
module pio_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val - 1'b1;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    expired = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pio_pin_bank.sv
// Per-pin value and configuration state plus driver encoding.
module pio_pin_bank #(
  parameter int NPIO = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIO-1:0] val_we,
  input  logic [NPIO-1:0] val_bits,
  input  logic [NPIO-1:0] cfg_ld,
  input  logic            follow_cfg,
  input  logic [NPIO-1:0] cfg_dir,
  input  logic [NPIO-1:0] cfg_od,
  input  logic [NPIO-1:0] tri_mask,
  output logic [NPIO-1:0] pio_out,
  output logic [NPIO-1:0] pio_oe
);
  for (genvar g = 0; g < NPIO; g++) begin : g_pin
    logic val_q, dir_q, od_q;
    logic dir_e, od_e;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= 1'b0;
        dir_q <= 1'b0;
        od_q  <= 1'b0;
      end else begin
        if (val_we[g]) val_q <= val_bits[g];
        if (follow_cfg || cfg_ld[g]) begin
          dir_q <= cfg_dir[g];
          od_q  <= cfg_od[g];
        end
      end
    end

    always_comb begin
      dir_e      = follow_cfg ? cfg_dir[g] : dir_q;
      od_e       = follow_cfg ? cfg_od[g]  : od_q;
      pio_oe[g]  = dir_e & ~tri_mask[g] & (~od_e | ~val_q);
      pio_out[g] = ~od_e & val_q;
    end
  end
endmodule

// File: rtl/pio_seq_writer.sv
module pio_seq_writer
  import pio_seq_pkg::*;
#(
  parameter int GRP_A_W  = 8,
  parameter int GRP_B_W  = 4,
  parameter int TRI_CYC  = 200,
  parameter int RAMP_CYC = 100,
  parameter int GAP_CYC  = 100
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            wr_start,
  input  logic                            wr_grp_b,
  input  logic                            wr_enable,
  input  logic                            byte_rx,
  input  logic [GRP_A_W-1:0]              byte_data,
  input  logic                            sck_fall,
  input  logic                            hc_mode,
  input  logic [GRP_A_W+GRP_B_W-1:0]      cfg_dir,
  input  logic [GRP_A_W+GRP_B_W-1:0]      cfg_od,
  output logic [GRP_A_W+GRP_B_W-1:0]      pio_out,
  output logic [GRP_A_W+GRP_B_W-1:0]      pio_oe,
  output logic                            busy
);
  localparam int NPIO    = GRP_A_W + GRP_B_W;
  localparam int IDX_W   = $clog2(NPIO);
  localparam int MAX_TR  = (TRI_CYC > RAMP_CYC) ? TRI_CYC : RAMP_CYC;
  localparam int CNT_MAX = (MAX_TR > GAP_CYC) ? MAX_TR : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [IDX_W-1:0] IDX_A_LAST  = IDX_W'(GRP_A_W - 1);
  localparam logic [IDX_W-1:0] IDX_B_FIRST = IDX_W'(GRP_A_W);
  localparam logic [IDX_W-1:0] IDX_LAST    = IDX_W'(NPIO - 1);
  localparam logic [NPIO-1:0]  MASK_A      = {{GRP_B_W{1'b0}}, {GRP_A_W{1'b1}}};
  localparam logic [NPIO-1:0]  MASK_B      = ~MASK_A;

  logic               commit, cs_rise;
  logic [GRP_A_W-1:0] commit_data;

  seq_state_e         st_q, st_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [GRP_A_W-1:0] seq_byte_q, seq_byte_d;
  logic [GRP_A_W-1:0] hold_byte_q, hold_byte_d;
  logic               hold_v_q, hold_v_d;
  logic               txn_ok_q, txn_ok_d;
  logic               txn_b_q, txn_b_d;
  logic               cur_b_q, cur_b_d;
  logic [1:0]         taken_q, taken_d;

  logic               tmr_load, tmr_exp;
  logic [CNT_W-1:0]   tmr_val;

  logic               grp_b_now, acc_first, acc_more, acc_b, lc_take, hc_start;
  logic [NPIO-1:0]    lc_we, pin_ld, tri_mask, bank_bits;

  pio_commit_trig #(.BYTE_W(GRP_A_W)) i_trig (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .byte_rx(byte_rx),
    .byte_data(byte_data), .sck_fall(sck_fall), .commit(commit),
    .commit_data(commit_data), .cs_rise(cs_rise)
  );

  pio_delay_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_exp)
  );

  // Byte acceptance and write-group tracking
  always_comb begin
    busy      = (st_q != SEQ_IDLE);
    grp_b_now = (taken_q == 2'd0) ? txn_b_q : cur_b_q;
    acc_first = commit && txn_ok_q && (taken_q == 2'd0) && !busy;
    acc_more  = commit && txn_ok_q && !hc_mode && !busy && !txn_b_q &&
                (taken_q != 2'd0);
    lc_take   = !hc_mode && (acc_first || acc_more);
    hc_start  = hc_mode && acc_first;
    acc_b     = commit && txn_ok_q && busy && !txn_b_q &&
                (taken_q == 2'd1) && !hold_v_q && (idx_q <= IDX_A_LAST);
    lc_we     = lc_take ? (grp_b_now ? MASK_B : MASK_A) : '0;
  end

  // Next-state logic: write bookkeeping and pin sequencer
  always_comb begin
    txn_ok_d    = txn_ok_q;
    txn_b_d     = txn_b_q;
    cur_b_d     = cur_b_q;
    taken_d     = taken_q;
    hold_v_d    = hold_v_q;
    hold_byte_d = hold_byte_q;
    st_d        = st_q;
    idx_d       = idx_q;
    seq_byte_d  = seq_byte_q;
    tmr_load    = 1'b0;
    tmr_val     = CNT_W'(TRI_CYC);
    pin_ld      = '0;

    if (wr_start) begin
      txn_ok_d = wr_enable;
      txn_b_d  = wr_grp_b;
      cur_b_d  = wr_grp_b;
      taken_d  = 2'd0;
    end else begin
      if (lc_take) begin
        cur_b_d = ~grp_b_now;
        taken_d = 2'd1;
      end
      if (hc_start) taken_d = 2'd1;
      if (acc_b) begin
        taken_d     = 2'd2;
        hold_v_d    = 1'b1;
        hold_byte_d = commit_data;
      end
      if (cs_rise) txn_ok_d = 1'b0;
    end

    unique case (st_q)
      SEQ_IDLE: begin
        if (hc_start) begin
          st_d       = SEQ_TRI;
          idx_d      = txn_b_q ? IDX_B_FIRST : '0;
          seq_byte_d = commit_data;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(TRI_CYC);
        end
      end
      SEQ_TRI: begin
        if (tmr_exp) begin
          pin_ld   = NPIO'(1) << idx_q;
          st_d     = SEQ_RAMP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(RAMP_CYC);
        end
      end
      SEQ_RAMP: begin
        if (tmr_exp) begin
          if (idx_q == IDX_LAST) begin
            st_d     = SEQ_IDLE;
            hold_v_d = 1'b0;
          end else if (idx_q == IDX_A_LAST) begin
            if (hold_v_q || acc_b) begin
              st_d     = SEQ_GAP;
              tmr_load = 1'b1;
              tmr_val  = CNT_W'(GAP_CYC);
            end else begin
              st_d = SEQ_IDLE;
            end
          end else begin
            idx_d    = idx_q + 1'b1;
            st_d     = SEQ_TRI;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(TRI_CYC);
          end
        end
      end
      SEQ_GAP: begin
        if (tmr_exp) begin
          idx_d      = IDX_B_FIRST;
          seq_byte_d = hold_byte_q;
          hold_v_d   = 1'b0;
          st_d       = SEQ_TRI;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(TRI_CYC);
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      idx_q       <= '0;
      seq_byte_q  <= '0;
      hold_byte_q <= '0;
      hold_v_q    <= 1'b0;
      txn_ok_q    <= 1'b0;
      txn_b_q     <= 1'b0;
      cur_b_q     <= 1'b0;
      taken_q     <= 2'd0;
    end else begin
      st_q        <= st_d;
      idx_q       <= idx_d;
      seq_byte_q  <= seq_byte_d;
      hold_byte_q <= hold_byte_d;
      hold_v_q    <= hold_v_d;
      txn_ok_q    <= txn_ok_d;
      txn_b_q     <= txn_b_d;
      cur_b_q     <= cur_b_d;
      taken_q     <= taken_d;
    end
  end

  always_comb begin
    tri_mask  = (st_q == SEQ_TRI) ? (NPIO'(1) << idx_q) : '0;
    bank_bits = busy ? {seq_byte_q[GRP_B_W-1:0], seq_byte_q}
                     : {commit_data[GRP_B_W-1:0], commit_data};
  end

  pio_pin_bank #(.NPIO(NPIO)) i_bank (
    .clk(clk), .rst_n(rst_n), .val_we(lc_we | pin_ld), .val_bits(bank_bits),
    .cfg_ld(pin_ld), .follow_cfg(!hc_mode && !busy), .cfg_dir(cfg_dir),
    .cfg_od(cfg_od), .tri_mask(tri_mask), .pio_out(pio_out), .pio_oe(pio_oe)
  );
endmodule

// File: rtl/pio_seq_writer_chk.sv
module pio_seq_writer_chk #(
  parameter int NPIO  = 12,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hc_mode,
  input logic             busy,
  input logic [NPIO-1:0]  cfg_dir,
  input logic [NPIO-1:0]  pio_oe,
  input logic [NPIO-1:0]  tri_mask,
  input logic [IDX_W-1:0] seq_idx
);
  AST_ONE_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tri_mask)); // R5
  AST_RELEASED_NOT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mask & pio_oe) == '0); // R5
  AST_PIN_ORDER_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (seq_idx != $past(seq_idx))) |-> (seq_idx == $past(seq_idx) + 1'b1)); // R5
  AST_IDLE_NOTHING_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tri_mask == '0)); // R8
  AST_BUSY_ONLY_SEQUENCED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hc_mode)); // R8
  AST_INPUTS_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!hc_mode && !busy) |-> ((pio_oe & ~cfg_dir) == '0)); // R9
endmodule

bind pio_seq_writer pio_seq_writer_chk #(.NPIO(NPIO), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .hc_mode(hc_mode), .busy(busy), .cfg_dir(cfg_dir),
  .pio_oe(pio_oe), .tri_mask(tri_mask), .seq_idx(idx_q)
);

// File: tb/test_pio_seq_writer.sv
module test_pio_seq_writer;
  localparam int T_C = 5;
  localparam int R_C = 3;
  localparam int G_C = 4;
  localparam int P_C = T_C + R_C;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, wr_start, wr_grp_b, wr_enable, byte_rx, sck_fall, hc_mode;
  logic [7:0]  byte_data;
  logic [11:0] cfg_dir, cfg_od, pio_out, pio_oe;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] m_val, m_dir, m_od;

  pio_seq_writer #(.TRI_CYC(T_C), .RAMP_CYC(R_C), .GAP_CYC(G_C)) i_pio_seq_writer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_start(wr_start), .wr_grp_b(wr_grp_b),
    .wr_enable(wr_enable), .byte_rx(byte_rx), .byte_data(byte_data),
    .sck_fall(sck_fall), .hc_mode(hc_mode), .cfg_dir(cfg_dir), .cfg_od(cfg_od),
    .pio_out(pio_out), .pio_oe(pio_oe), .busy(busy)
  );

  always #5 clk = ~clk;

  function automatic logic [11:0] f_oe(logic [11:0] v, logic [11:0] d, logic [11:0] o);
    return d & (~o | ~v);
  endfunction
  function automatic logic [11:0] f_out(logic [11:0] v, logic [11:0] o);
    return ~o & v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic start_txn(input bit grp_b, input bit wen);
    @(negedge clk); cs_n = 1'b0; wr_start = 1'b1; wr_grp_b = grp_b; wr_enable = wen;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic lc_check(input string req);
    chk({req, " R9 out"}, 32'(pio_out), 32'(f_out(m_val, cfg_od)));
    chk({req, " R9 oe"},  32'(pio_oe),  32'(f_oe(m_val, cfg_dir, cfg_od)));
    chk({req, " busy"},   32'(busy), 32'd0);
  endtask

  // Simultaneous-mode write with model update
  task automatic lc_txn(input bit ga, input bit wen, input int nb, input bit cs_last);
    start_txn(!ga, wen);
    for (int i = 0; i < nb; i++) begin
      logic [7:0] d;
      string tag;
      d = 8'($urandom);
      @(negedge clk); byte_rx = 1'b1; byte_data = d;
      @(negedge clk); byte_rx = 1'b0;
      if (!wen) tag = "R2";
      else if (ga) tag = "R3 R4";
      else tag = (i == 0) ? "R3" : "R4";
      if (wen) begin
        if (ga && (i % 2 == 0)) m_val[7:0] = d;
        else if (ga || i == 0) m_val[11:8] = d[3:0];
      end
      if (i == nb - 1 && cs_last) begin
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        lc_check({tag, " R1"});
      end else begin
        @(negedge clk); sck_fall = 1'b1;
        @(negedge clk); sck_fall = 1'b0;
        lc_check({tag, " R1"});
      end
    end
    if (!cs_last) begin
      @(negedge clk); cs_n = 1'b1;
      @(negedge clk);
      lc_check("R1");
    end
  endtask

  // Sequenced-mode write, checked cycle by cycle
  task automatic hc_run(input bit ga, input bit two);
    logic [11:0] ov, odr, oo, nv, nd, no, seqm;
    logic [7:0]  d1, d2;
    int endn;
    ov = m_val; odr = m_dir; oo = m_od;
    nv = ov; nd = odr; no = oo; seqm = '0;
    d1 = 8'($urandom); d2 = 8'($urandom);
    for (int k = 0; k < 12; k++) begin
      if ((ga && k < 8) || (!ga && k >= 8)) begin
        nv[k] = (k < 8) ? d1[k] : d1[k-8];
        seqm[k] = 1'b1;
      end else if (ga && two) begin
        nv[k] = d2[k-8];
        seqm[k] = 1'b1;
      end
      if (seqm[k]) begin nd[k] = cfg_dir[k]; no[k] = cfg_od[k]; end
    end
    endn = ga ? (two ? 12*P_C + G_C : 8*P_C) : 4*P_C;
    start_txn(!ga, 1'b1);
    @(negedge clk); byte_rx = 1'b1; byte_data = d1;
    @(negedge clk); byte_rx = 1'b0;
    @(negedge clk); sck_fall = 1'b1;
    @(negedge clk); sck_fall = 1'b0;
    for (int n = 0; n < endn + 4; n++) begin
      logic [11:0] eoe, eout, o_oe, o_out, n_oe, n_out;
      o_oe = f_oe(ov, odr, oo); o_out = f_out(ov, oo);
      n_oe = f_oe(nv, nd, no);  n_out = f_out(nv, no);
      for (int k = 0; k < 12; k++) begin
        int off;
        if (ga) off = (k < 8) ? k*P_C : 8*P_C + G_C + (k-8)*P_C;
        else    off = (k - 8) * P_C;
        if (!seqm[k] || n < off) begin
          eoe[k] = o_oe[k]; eout[k] = o_out[k];
        end else if (n < off + T_C) begin
          eoe[k] = 1'b0; eout[k] = o_out[k];
        end else begin
          eoe[k] = n_oe[k]; eout[k] = n_out[k];
        end
      end
      chk("R5 R6 oe",  32'(pio_oe),  32'(eoe));
      chk("R5 R6 out", 32'(pio_out), 32'(eout));
      chk("R8 busy",   32'(busy),    32'(n < endn));
      if (two) begin
        if (n == 10) begin byte_rx = 1'b1; byte_data = d2; end
        if (n == 11) byte_rx = 1'b0;
        if (n == 13) sck_fall = 1'b1;
        if (n == 14) sck_fall = 1'b0;
      end
      if (two || !ga) begin
        if (n == 20) begin byte_rx = 1'b1; byte_data = ~d1; end
        if (n == 21) byte_rx = 1'b0;
        if (n == 23) sck_fall = 1'b1;
        if (n == 24) sck_fall = 1'b0;
      end
      @(negedge clk);
    end
    cs_n = 1'b1;
    @(negedge clk);
    m_val = nv; m_dir = nd; m_od = no;
    chk("R8 R5 final oe", 32'(pio_oe), 32'(f_oe(m_val, m_dir, m_od)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    summary();
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst_n = 1'b0; cs_n = 1'b1; wr_start = 1'b0; wr_grp_b = 1'b0; wr_enable = 1'b0;
    byte_rx = 1'b0; byte_data = '0; sck_fall = 1'b0; hc_mode = 1'b0;
    cfg_dir = '0; cfg_od = '0;
    m_val = '0; m_dir = '0; m_od = '0;
    repeat (3) @(negedge clk);
    chk("R10 out in reset", 32'(pio_out), 32'd0);
    chk("R10 oe in reset", 32'(pio_oe), 32'd0);
    chk("R10 busy in reset", 32'(busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 out after reset", 32'(pio_out), 32'd0);
    cfg_dir = 12'hFFF; cfg_od = 12'h0F0;
    @(negedge clk);
    lc_check("R9 R10 cfg follow");

    // directed simultaneous-mode cases
    lc_txn(1'b1, 1'b1, 4, 1'b1);
    lc_txn(1'b0, 1'b1, 3, 1'b0);
    lc_txn(1'b1, 1'b0, 2, 1'b0);
    lc_txn(1'b0, 1'b1, 1, 1'b1);

    // random simultaneous-mode writes
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      cfg_dir = 12'($urandom); cfg_od = 12'($urandom);
      @(negedge clk);
      lc_check("R9 cfg change");
      lc_txn(1'($urandom), ($urandom % 4) != 0, 1 + int'($urandom % 4), 1'($urandom));
    end

    // sequenced mode
    @(negedge clk);
    cfg_dir = 12'hF3F; cfg_od = 12'h0C1;
    @(negedge clk);
    hc_mode = 1'b1; m_dir = cfg_dir; m_od = cfg_od;
    @(negedge clk);
    lc_check("R9 mode switch");

    // write not enabled: nothing starts
    start_txn(1'b0, 1'b0);
    @(negedge clk); byte_rx = 1'b1; byte_data = 8'hA5;
    @(negedge clk); byte_rx = 1'b0;
    @(negedge clk); sck_fall = 1'b1;
    @(negedge clk); sck_fall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 hc no busy", 32'(busy), 32'd0);
    chk("R2 hc oe unchanged", 32'(pio_oe), 32'(f_oe(m_val, m_dir, m_od)));
    cs_n = 1'b1;
    @(negedge clk);

    hc_run(1'b1, 1'b1);

    // configuration change deferred
    cfg_dir = ~cfg_dir; cfg_od = ~cfg_od;
    repeat (4) @(negedge clk);
    chk("R7 oe held", 32'(pio_oe), 32'(f_oe(m_val, m_dir, m_od)));
    chk("R7 out held", 32'(pio_out), 32'(f_out(m_val, m_od)));

    hc_run(1'b0, 1'b0);
    chk("R7 wide group still old cfg", 32'(pio_oe[7:0]), 32'(f_oe(m_val, m_dir, m_od) & 12'h0FF));
    hc_run(1'b1, 1'b0);
    cfg_dir = 12'($urandom); cfg_od = 12'($urandom);
    @(negedge clk);
    hc_run(1'b1, 1'b1);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule